// File: doc/BRIEF.md
# Register-Controlled Countdown Watchdog

This block is a one-shot watchdog timer. Software programs it through a small register port, which has a 2-bit address, 8-bit write data, a write strobe and combinational read data. A write of a non-zero value to the count register loads that value and starts a countdown. A write of zero stops the timer.

Each count step lasts a number of clock cycles set by a prescaler. One mode bit picks between a short divide ratio and a long divide ratio, which stand for seconds and minutes. When the count reaches zero, a timeout flag is set and the active-low timeout output is held low. The output stays low until software writes zero to the flag bit. That write also reloads the last non-zero value that was written and starts counting again.

Two active-low synchronous reset inputs can return the block to its reset state. A select input chooses which of the two is honoured.

Top module: `wdg_top`

## Requirements
- R1: After reset the enable register reads 0x00, the mode register reads 0x00, the count register reads 4, the status register reads 0x00, and `wdt_out_n` is 1.
- R2: Address 0 holds the enable bit in bit 0 and can always be written. While that bit is 0, writes to addresses 1, 2 and 3 have no effect.
- R3: With the enable bit at 1 and the flag clear, a write of N≠0 to address 2 makes the count read N in the next cycle. The count then drops by one every D cycles. D is SEC_DIV when mode bit 3 (address 1) is 0 and MIN_DIV when it is 1.
- R4: A write of 0 to address 2 makes the count read 0. After that the count does not change and the flag is never set.
- R5: A write of a new non-zero count while counting takes effect in the next cycle, and the step timing restarts from it.
- R6: On the edge where the count goes from 1 to 0, the flag (bit 4 of address 3) is set and `wdt_out_n` goes to 0. The count then stays at 0.
- R7: While the flag is set, `wdt_out_n` stays 0. A write with bit 4 set to 1 at address 3 does not change the flag.
- R8: A write with bit 4 set to 0 at address 3 while the flag is set clears the flag and raises `wdt_out_n` in the next cycle. The count reloads the last non-zero value written, or 4 if none has been written since reset, and counting starts again.
- R9: Clearing the enable bit while counting freezes the count. Setting it again resumes the count.
- R10: When `rst_src_sel` is 0, only `rst_a_n` resets the block. When it is 1, only `rst_b_n` resets the block.
- R11: Read data depends only on the address and the current state: address 0 gives the enable bit, address 1 gives the unit bit in bit 3, address 2 gives the live count, and address 3 gives the flag in bit 4. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_a_n | input | 1 | Reset source A, synchronous, active low |
| rst_b_n | input | 1 | Reset source B, synchronous, active low |
| rst_src_sel | input | 1 | 0 selects source A, 1 selects source B |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| wdt_out_n | output | 1 | Timeout output, low while the flag is set |

## Verification
- **Register writes:** a write sampled on edge E is visible at the read port and at `wdt_out_n` just after E. The bench therefore samples at the falling edge that follows the write.
- **Countdown steps:** after a load on edge E, step k lands on edge E+k·D. The timeout appears on edge E+N·D.
- **Directed checks:** the bench waits a counted number of falling edges and checks the values one cycle before a step and one cycle after it.
- **Per-cycle comparison:** a behavioural model in the bench is updated on each rising edge. On every falling edge it is compared with the read data and with the timeout output.

// File: rtl/wdg_pkg.sv
// Shared definitions for the countdown watchdog: register addresses,
// bit positions inside the registers, and the reset count.
package wdg_pkg;
    typedef enum logic [1:0] {
        A_ENABLE = 2'd0,
        A_MODE   = 2'd1,
        A_COUNT  = 2'd2,
        A_STATUS = 2'd3
    } wdg_addr_e;

    localparam int EN_BIT      = 0;
    localparam int UNIT_BIT    = 3;
    localparam int FLAG_BIT    = 4;
    localparam int CNT_RST_VAL = 4;
endpackage

// File: rtl/wdg_regs.sv
// Register decode for the watchdog.
// It holds the enable bit and the unit bit, and it turns writes into
// load and flag-clear strobes for the counter core.
// It also drives the combinational read data.
// Assumes DW >= 5, so that the flag bit position exists.
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic [DW-1:0] cnt_q,
    input  logic          flag_q,
    output logic          en_q,
    output logic          unit_q,
    output logic          cnt_ld,
    output logic [DW-1:0] ld_val,
    output logic          flag_clr,
    output logic [DW-1:0] rdata
);
    // Write strobes. The enable register is the only one writable
    // while the circuit is off.
    always_comb begin
        cnt_ld   = wr && (addr == A_COUNT) && en_q;
        ld_val   = wdata;
        flag_clr = wr && (addr == A_STATUS) && en_q && !wdata[FLAG_BIT];
    end

    // Storage for the enable bit and the unit bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            unit_q <= 1'b0;
        end else if (wr) begin
            if (addr == A_ENABLE)
                en_q <= wdata[EN_BIT];
            if (addr == A_MODE && en_q)
                unit_q <= wdata[UNIT_BIT];
        end
    end

    // Read mux. Unused bits read as zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_ENABLE: rdata[EN_BIT]   = en_q;
            A_MODE:   rdata[UNIT_BIT] = unit_q;
            A_COUNT:  rdata           = cnt_q;
            default:  rdata[FLAG_BIT] = flag_q;
        endcase
    end

    // R2: the mode bit cannot change while the circuit is off.
    a_r2_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && wr && addr == A_MODE) |=> $stable(unit_q));
endmodule

// File: rtl/wdg_tick.sv
// Prescaler for the watchdog.
// It produces one tick every SEC_DIV or MIN_DIV cycles of run time,
// chosen by the unit bit.
// While run is low the phase is held. A clear pulse restarts the phase.
// Assumes both divide ratios are at least 1.
module wdg_tick #(
    parameter int SEC_DIV = 4,
    parameter int MIN_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic unit,
    output logic tick
);
    localparam int MAXD = (SEC_DIV > MIN_DIV) ? SEC_DIV : MIN_DIV;
    localparam int PW   = (MAXD > 1) ? $clog2(MAXD + 1) : 1;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] lim;

    // Last phase value of the selected unit.
    always_comb begin
        lim  = unit ? PW'(MIN_DIV - 1) : PW'(SEC_DIV - 1);
        tick = run && (pcnt >= lim);
    end

    // Phase counter. Clear wins over run, and it wraps on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (clr)
            pcnt <= '0;
        else if (run)
            pcnt <= tick ? '0 : pcnt + PW'(1);
    end

    // R5: a reload restarts the step phase.
    a_r5_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pcnt == '0));
endmodule

// File: rtl/wdg_core.sv
// Countdown core of the watchdog.
// It holds the live count, the value restored on a restart, and the
// timeout flag.
// The order of precedence is: load, then flag clear, then tick.
// Assumes the strobes from the register decode are already gated by enable.
module wdg_core
    import wdg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cnt_ld,
    input  logic [DW-1:0] ld_val,
    input  logic          flag_clr,
    input  logic          tick,
    output logic [DW-1:0] cnt_q,
    output logic          flag_q,
    output logic          active,
    output logic          pre_clr
);
    logic [DW-1:0] rel_q;
    logic          restart;

    // Counting condition and prescaler restart.
    always_comb begin
        active  = en && (cnt_q != '0) && !flag_q;
        restart = flag_clr && flag_q;
        pre_clr = cnt_ld || restart;
    end

    // Count, reload value and flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= DW'(CNT_RST_VAL);
            rel_q  <= DW'(CNT_RST_VAL);
            flag_q <= 1'b0;
        end else if (cnt_ld) begin
            cnt_q <= ld_val;
            if (ld_val != '0)
                rel_q <= ld_val;
        end else if (restart) begin
            flag_q <= 1'b0;
            cnt_q  <= rel_q;
        end else if (active && tick) begin
            cnt_q <= cnt_q - DW'(1);
            if (cnt_q == DW'(1))
                flag_q <= 1'b1;
        end
    end

    // R3: a tick with no load lowers the count by exactly one.
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && !cnt_ld) |=> (cnt_q == $past(cnt_q) - DW'(1)));
    // R6: the last step sets the flag and leaves the count at zero.
    a_r6_flag_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && !cnt_ld && cnt_q == DW'(1)) |=> (flag_q && cnt_q == '0));
    // R7: only a clearing write can drop the flag.
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
    // R8: a clear restarts with a non-zero count.
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!flag_q && cnt_q != '0));
    // R9: while disabled, the count is frozen.
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_ld && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_top.sv
// Countdown watchdog top level.
// It selects the reset source and connects the register decode, the
// prescaler and the countdown core.
// Both reset inputs are synchronous and active low.
// rst_src_sel is expected to be static around any reset pulse.
module wdg_top #(
    parameter int DW      = 8,
    parameter int SEC_DIV = 4,
    parameter int MIN_DIV = 12
) (
    input  logic          clk,
    input  logic          rst_a_n,
    input  logic          rst_b_n,
    input  logic          rst_src_sel,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_wr,
    output logic [DW-1:0] reg_rdata,
    output logic          wdt_out_n
);
    logic          rst_n;
    logic          en_q;
    logic          unit_q;
    logic          cnt_ld;
    logic          flag_clr;
    logic          flag_q;
    logic          active;
    logic          pre_clr;
    logic          tick;
    logic [DW-1:0] ld_val;
    logic [DW-1:0] cnt_q;

    // Reset source selection and timeout output level.
    always_comb begin
        rst_n     = rst_src_sel ? rst_b_n : rst_a_n;
        wdt_out_n = !flag_q;
    end

    wdg_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .wr       (reg_wr),
        .cnt_q    (cnt_q),
        .flag_q   (flag_q),
        .en_q     (en_q),
        .unit_q   (unit_q),
        .cnt_ld   (cnt_ld),
        .ld_val   (ld_val),
        .flag_clr (flag_clr),
        .rdata    (reg_rdata)
    );

    wdg_tick #(.SEC_DIV(SEC_DIV), .MIN_DIV(MIN_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .run   (active),
        .unit  (unit_q),
        .tick  (tick)
    );

    wdg_core #(.DW(DW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .cnt_ld   (cnt_ld),
        .ld_val   (ld_val),
        .flag_clr (flag_clr),
        .tick     (tick),
        .cnt_q    (cnt_q),
        .flag_q   (flag_q),
        .active   (active),
        .pre_clr  (pre_clr)
    );

    // R10: the reset selected by rst_src_sel returns the block to its reset state.
    a_r10_reset_state: assert property (@(posedge clk)
        !rst_n |=> (wdt_out_n && cnt_q == DW'(4) && !en_q));
endmodule

// File: tb/sim_wdg_top.sv
module sim_wdg_top;
    localparam int CLK_PERIOD = 10;
    localparam int SEC_DIV    = 4;
    localparam int MIN_DIV    = 12;

    logic       clk = 1'b0;
    logic       rst_a_n = 1'b0;
    logic       rst_b_n = 1'b1;
    logic       rst_src_sel = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_rdata;
    logic       wdt_out_n;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state.
    logic       m_en = 1'b0;
    logic       m_unit = 1'b0;
    logic       m_flag = 1'b0;
    logic [7:0] m_cnt = 8'd4;
    logic [7:0] m_rel = 8'd4;
    int         m_pc = 0;

    wdg_top #(.DW(8), .SEC_DIV(SEC_DIV), .MIN_DIV(MIN_DIV)) u0 (
        .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .rst_src_sel(rst_src_sel),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rdata(reg_rdata), .wdt_out_n(wdt_out_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: one step per rising edge.
    always @(posedge clk) begin
        bit rst;
        bit act;
        int div;
        rst = rst_src_sel ? !rst_b_n : !rst_a_n;
        if (rst) begin
            m_en = 0; m_unit = 0; m_flag = 0; m_cnt = 4; m_rel = 4; m_pc = 0;
        end else begin
            act = m_en && (m_cnt != 0) && !m_flag;
            div = m_unit ? MIN_DIV : SEC_DIV;
            if (reg_wr && reg_addr == 2 && m_en) begin
                m_cnt = reg_wdata;
                if (reg_wdata != 0) m_rel = reg_wdata;
                m_pc = 0;
            end else if (reg_wr && reg_addr == 3 && m_en && !reg_wdata[4] && m_flag) begin
                m_flag = 0; m_cnt = m_rel; m_pc = 0;
            end else if (act) begin
                if (m_pc + 1 >= div) begin
                    m_pc = 0;
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) m_flag = 1;
                end else begin
                    m_pc++;
                end
            end
            if (reg_wr && reg_addr == 1 && m_en) m_unit = reg_wdata[3];
            if (reg_wr && reg_addr == 0) m_en = reg_wdata[0];
        end
    end

    function automatic logic [7:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: model_rd = {7'd0, m_en};
            2'd1: model_rd = {4'd0, m_unit, 3'd0};
            2'd2: model_rd = m_cnt;
            default: model_rd = {3'd0, m_flag, 4'd0};
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_a_n && rst_b_n) begin
            check(wdt_out_n == !m_flag, "R6 output vs model", wdt_out_n, !m_flag);
            check(reg_rdata == model_rd(reg_addr), "R11 read vs model", reg_rdata, model_rd(reg_addr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        cyc(3);
        rst_a_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd(0, 8'h00, "R1 enable"); rd(1, 8'h00, "R1 mode");
        rd(2, 8'h04, "R1 count"); rd(3, 8'h00, "R1 status");
        check(wdt_out_n == 1'b1, "R1 output", wdt_out_n, 1);
        // R2 writes ignored while disabled
        wr(2, 8'd9); rd(2, 8'd4, "R2 count locked");
        wr(1, 8'h08); rd(1, 8'h00, "R2 mode locked");
        // enable
        wr(0, 8'h01); rd(0, 8'h01, "R11 enable read");
        // R3 load and seconds step
        wr(2, 8'd3); reg_addr = 2;
        cyc(3); rd(2, 8'd3, "R3 before step");
        cyc(1); rd(2, 8'd2, "R3 after step");
        // R5 rewrite while counting
        wr(2, 8'd5); rd(2, 8'd5, "R5 reload");
        cyc(3); rd(2, 8'd5, "R5 phase restarted");
        cyc(1); rd(2, 8'd4, "R5 step");
        // R9 disable freezes
        wr(0, 8'h00); reg_addr = 2; #1 held = reg_rdata;
        cyc(20); rd(2, held, "R9 frozen");
        wr(0, 8'h01);
        // R6 timeout
        wr(2, 8'd2); reg_addr = 2;
        cyc(7); check(wdt_out_n == 1'b1, "R6 before zero", wdt_out_n, 1); rd(2, 8'd1, "R6 count one");
        cyc(1); check(wdt_out_n == 1'b0, "R6 timeout", wdt_out_n, 0);
        rd(3, 8'h10, "R6 flag"); rd(2, 8'd0, "R6 count zero");
        // R7 level held, writing 1 has no effect
        cyc(30); check(wdt_out_n == 1'b0, "R7 held", wdt_out_n, 0);
        wr(3, 8'h10); rd(3, 8'h10, "R7 write one"); check(wdt_out_n == 1'b0, "R7 still low", wdt_out_n, 0);
        // R8 clear and reload
        wr(3, 8'h00); check(wdt_out_n == 1'b1, "R8 released", wdt_out_n, 1);
        rd(2, 8'd2, "R8 reload value");
        // R4 stop
        wr(2, 8'd0); cyc(50);
        rd(2, 8'd0, "R4 stopped"); check(wdt_out_n == 1'b1, "R4 no timeout", wdt_out_n, 1);
        // R3 minute unit
        wr(1, 8'h08); rd(1, 8'h08, "R3 unit bit");
        wr(2, 8'd1);
        cyc(MIN_DIV - 1); check(wdt_out_n == 1'b1, "R3 long unit early", wdt_out_n, 1);
        cyc(1); check(wdt_out_n == 1'b0, "R3 long unit timeout", wdt_out_n, 0);
        // R10 reset source select
        rst_b_n = 1'b0; cyc(2); rst_b_n = 1'b1;
        rd(0, 8'h01, "R10 source B ignored"); check(wdt_out_n == 1'b0, "R10 flag kept", wdt_out_n, 0);
        rst_src_sel = 1'b1;
        rst_b_n = 1'b0; cyc(2); rst_b_n = 1'b1;
        rd(0, 8'h00, "R10 source B reset"); rd(2, 8'd4, "R10 count reset");
        check(wdt_out_n == 1'b1, "R10 output reset", wdt_out_n, 1);
        wr(0, 8'h01);
        rst_a_n = 1'b0; cyc(2); rst_a_n = 1'b1;
        rd(0, 8'h01, "R10 source A ignored");
        // R8 default reload after reset: count from 4 in seconds unit
        reg_addr = 2;
        cyc(4 * SEC_DIV + 2);
        check(wdt_out_n == 1'b0, "R8 default timeout", wdt_out_n, 0);
        wr(3, 8'h00); rd(2, 8'd4, "R8 default reload");
        cyc(5);
        finish_run();
    end
endmodule